// File: doc/BRIEF.md
# Match-Wrapping Real-Time Seconds Counter

This block keeps a 32-bit count that advances once for every rising edge of a slow reference square wave (nominally 32.768 kHz) arriving on its own input pin, independent of the system clock. The reference is synchronized into the system clock domain and edge-detected. Each detected edge becomes a single-cycle tick that steps the counter.

Software programs a compare value. When a tick arrives while the count already equals that value, the count returns to zero instead of stepping, and a sticky match flag is raised. The flag is cleared by writing one to a clear register. An interrupt output follows the flag, gated by a mask bit.

The count only runs when three things are true: the configuration register selects clock mode, the run bit is set, and the clock-function bit is set. The configuration and compare registers are locked while the run bit is set.

Top module: `rtc_match_counter`

## Requirements
- R1: After reset every register reads zero: configuration, control, compare, mask, status and count. `irq_o` is low.
- R2: Word addresses are 0 configuration, 1 control (bit 0 run, bit 1 clock function), 2 compare, 3 mask (bit 0), 4 status (bit 0), 5 clear (bit 0, write-one), and 6 count. With configuration equal to 1 and both control bits set, the count rises by exactly one for each rising edge of `ref_clk_i`.
- R3: If the configuration is not 1, or either control bit is clear, edges on `ref_clk_i` leave the count unchanged.
- R4: A tick that arrives while the count equals the compare value loads the count with zero and sets status bit 0. A count equal to the compare value with no tick does not set status.
- R5: Writing 1 to clear bit 0 clears status bit 0. Writing 0 there leaves status unchanged.
- R6: If a match and a clear write fall in the same cycle, status ends set.
- R7: `irq_o` is high exactly when status bit 0 and mask bit 0 are both set.
- R8: Writes to the configuration and compare registers are ignored while the run bit is set. Control, mask and clear are always writable.
- R9: A reference held high for many system cycles gives only one increment.
- R10: The count is readable at any time, and unmapped addresses (7) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_clk_i | input | 1 | 32.768 kHz reference, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Masked match interrupt |

## Verification
Two events can land on the status flag in the same cycle: a compare hit that sets it and a software clear that resets it. The bench first parks the count on the compare value. It then raises the reference, counts two system edges through the synchronizer, and places a clear write so that it lands on the same edge as the tick. After that cycle the status must read one and the count zero. A separate clear with no tick must still bring the flag to zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CFG_W  = 3;
  localparam logic [CFG_W-1:0] CFG_RTC = 3'd1;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_MATCH  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;

  typedef struct packed {
    logic rtc_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rtc_sync_edge.sv
module rtc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             count_en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] match_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step  = count_en_i & tick_i;
  assign hit_o = step & (count_q == match_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    count_q <= '0;
    else if (hit_o) count_q <= '0;
    else if (step)  count_q <= count_q + 1'b1;

  assign count_o = count_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              hit_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CFG_W-1:0]  cfg_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  match_o,
  output logic              mask_o,
  output logic              status_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic [CFG_W-1:0] cfg_q;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] match_q;
  logic             mask_q, status_q;
  logic             locked, clr_req;

  assign locked  = ctrl_q.run;
  assign clr_req = wr_en_i & (wr_addr_i == A_CLEAR) & wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q   <= '0;
      ctrl_q  <= '0;
      match_q <= '0;
      mask_q  <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CFG:   if (!locked) cfg_q <= wr_data_i[CFG_W-1:0];
        A_CTRL:  ctrl_q <= '{rtc_en: wr_data_i[1], run: wr_data_i[0]};
        A_MATCH: if (!locked) match_q <= wr_data_i;
        A_MASK:  mask_q <= wr_data_i[0];
        default: ;
      endcase
    end

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      status_q <= 1'b0;
    else if (hit_i)   status_q <= 1'b1;
    else if (clr_req) status_q <= 1'b0;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CFG:    rd_data_o[CFG_W-1:0] = cfg_q;
      A_CTRL:   rd_data_o[1:0] = {ctrl_q.rtc_en, ctrl_q.run};
      A_MATCH:  rd_data_o = match_q;
      A_MASK:   rd_data_o[0] = mask_q;
      A_STATUS: rd_data_o[0] = status_q;
      A_COUNT:  rd_data_o = count_i;
      default:  rd_data_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign ctrl_o   = ctrl_q;
  assign match_o  = match_q;
  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = status_q & mask_q;
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic             tick_w, hit_w, counting_w;
  logic [CNT_W-1:0] count_w, match_w;
  logic [CFG_W-1:0] cfg_w;
  ctrl_t            ctrl_w;
  logic             mask_w, status_w;

  rtc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_clk_i), .rise_o(tick_w)
  );

  assign counting_w = ctrl_w.run & ctrl_w.rtc_en & (cfg_w == CFG_RTC);

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_en_i(counting_w), .tick_i(tick_w),
    .match_i(match_w), .count_o(count_w), .hit_o(hit_w)
  );

  rtc_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .hit_i(hit_w), .count_i(count_w),
    .cfg_o(cfg_w), .ctrl_o(ctrl_w), .match_o(match_w), .mask_o(mask_w),
    .status_o(status_w), .irq_o(irq_o), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rtc_match_counter_chk.sv
module rtc_match_counter_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             counting,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] match,
  input logic             status,
  input logic             mask,
  input logic             run,
  input logic             irq_o
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && tick && (count != match) |=> count == $past(count) + 1'b1);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !counting |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && tick && (count == match) |=> count == '0);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    counting && tick && (count == match) |=> status);

  assert_irq_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask |-> !irq_o);

  assert_match_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> $stable(match));

  assert_single_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);
endmodule

bind rtc_match_counter rtc_match_counter_chk #(.CNT_W(rtc_pkg::CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick_w), .counting(counting_w),
  .count(count_w), .match(match_w), .status(status_w), .mask(mask_w),
  .run(ctrl_w.run), .irq_o(irq_o)
);

// File: tb/rtc_match_counter_tb_top.sv
module rtc_match_counter_tb_top;
  import rtc_pkg::*;

  logic              clk = 1'b0, rst_ni = 1'b0, ref_clk = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0, rd_data;
  logic              irq;
  int unsigned       n_chk = 0, n_fail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  rtc_match_counter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ref_clk_i(ref_clk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PULSE = 2'd2, OP_IRQ = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;
  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, A_CFG, 32'd1, 4'd2}, '{OP_WR, A_MATCH, 32'd5, 4'd2},
    '{OP_WR, A_MASK, 32'd1, 4'd7}, '{OP_WR, A_CTRL, 32'd3, 4'd2},
    '{OP_PULSE, 3'd0, 32'd3, 4'd2}, '{OP_RD, A_COUNT, 32'd3, 4'd2},     // R2
    '{OP_PULSE, 3'd0, 32'd2, 4'd2}, '{OP_RD, A_COUNT, 32'd5, 4'd10},    // R10
    '{OP_RD, A_STATUS, 32'd0, 4'd4},                                    // R4 no tick
    '{OP_PULSE, 3'd0, 32'd1, 4'd4}, '{OP_RD, A_COUNT, 32'd0, 4'd4},     // R4 wrap
    '{OP_RD, A_STATUS, 32'd1, 4'd4}, '{OP_IRQ, 3'd0, 32'd1, 4'd7},      // R7
    '{OP_WR, A_CLEAR, 32'd0, 4'd5}, '{OP_RD, A_STATUS, 32'd1, 4'd5},    // R5
    '{OP_WR, A_CLEAR, 32'd1, 4'd5}, '{OP_RD, A_STATUS, 32'd0, 4'd5},
    '{OP_IRQ, 3'd0, 32'd0, 4'd7},
    '{OP_WR, A_MATCH, 32'd2, 4'd8}, '{OP_RD, A_MATCH, 32'd5, 4'd8},     // R8
    '{OP_WR, A_CFG, 32'd2, 4'd8}, '{OP_RD, A_CFG, 32'd1, 4'd8},
    '{OP_WR, A_CTRL, 32'd1, 4'd3}, '{OP_PULSE, 3'd0, 32'd2, 4'd3},      // R3
    '{OP_RD, A_COUNT, 32'd0, 4'd3},
    '{OP_WR, A_CTRL, 32'd0, 4'd3}, '{OP_WR, A_CFG, 32'd4, 4'd3},
    '{OP_WR, A_CTRL, 32'd3, 4'd3}, '{OP_PULSE, 3'd0, 32'd2, 4'd3},
    '{OP_RD, A_COUNT, 32'd0, 4'd3},
    '{OP_WR, A_CTRL, 32'd0, 4'd8}, '{OP_WR, A_CFG, 32'd1, 4'd8},
    '{OP_WR, A_MATCH, 32'd1, 4'd8}, '{OP_WR, A_CTRL, 32'd3, 4'd2},
    '{OP_PULSE, 3'd0, 32'd1, 4'd2}, '{OP_RD, A_COUNT, 32'd1, 4'd2},
    '{OP_PULSE, 3'd0, 32'd1, 4'd4}, '{OP_RD, A_STATUS, 32'd1, 4'd4},
    '{OP_WR, A_MASK, 32'd0, 4'd7}, '{OP_IRQ, 3'd0, 32'd0, 4'd7},
    '{OP_RD, 3'd7, 32'd0, 4'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_addr = a; #1;
    check(tag, rd_data, exp);
  endtask

  task automatic pulse(input int n, input int high);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_clk = 1'b1;
      repeat (high) @(negedge clk);
      ref_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a < 7; a++) rd(a[2:0], 32'd0, "R1 reset");
    check("R1 irq", {31'd0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec %0d", VEC[i].req, i);
      case (VEC[i].op)
        OP_WR:    wr(VEC[i].addr, VEC[i].data);
        OP_RD:    rd(VEC[i].addr, VEC[i].data, tag);
        OP_PULSE: pulse(int'(VEC[i].data), 4);
        default:  begin @(negedge clk); check(tag, {31'd0, irq}, VEC[i].data); end
      endcase
    end

    // R9: long high level counts once (count 0 -> 1, match 1)
    wr(A_CLEAR, 32'd1);
    pulse(1, 40);
    rd(A_COUNT, 32'd1, "R9 long level");
    rd(A_STATUS, 32'd0, "R9 status");

    // R6: tick at match and clear write in the same cycle
    @(negedge clk); ref_clk = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = A_CLEAR; wr_data = 32'd1;
    @(negedge clk); wr_en = 1'b0;
    rd(A_STATUS, 32'd1, "R6 set wins");
    rd(A_COUNT, 32'd0, "R6 wrapped");
    @(negedge clk); ref_clk = 1'b0;
    repeat (4) @(negedge clk);
    wr(A_CLEAR, 32'd1);
    rd(A_STATUS, 32'd0, "R6 lone clear");

    // R1 reset mid-run
    pulse(1, 4);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd(A_COUNT, 32'd0, "R1 count after reset");
    rd(A_CTRL, 32'd0, "R1 ctrl after reset");
    rd(A_MATCH, 32'd0, "R1 match after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule